// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the sequence of word addresses for a synchronous burst read from a memory array. A burst begins when `start_i` is pulsed with a start address and a configuration. The configuration covers the burst length (four words, eight words or unbounded), the order (sequential or XOR-interleaved) and whether a sequential burst stays inside its aligned block or runs on past the block's end. From the next cycle the block presents one address per beat. It moves to the next beat on each cycle in which `advance_i` is high.

A fixed-length burst that is not confined to its block may step onto a new eight-word-aligned row. On that beat the block drives the active-low `wait_n_o` low. A configuration input can move this marker one beat earlier, so that the reader gets advance warning. An interleaved order cannot be combined with the unbounded length or with the unconfined mode. If it is requested with either, the block flags `cfg_err_o` for one cycle and runs the burst in sequential order.

Top module: `burst_seq_gen`

## Requirements
- R1: The cycle after `start_i` is sampled high, `addr_valid_o` is 1 and `addr_o` equals the sampled `start_addr_i`. A `start_i` during an active burst abandons that burst and begins the new one, and it takes priority over `stop_i`.
- R2: While a burst is active and `advance_i`, `stop_i` and `start_i` are all low, `addr_o`, `wait_n_o` and `addr_valid_o` hold their values. Each sampled `advance_i` moves to the next beat k+1.
- R3: Interleaved order (`interleave_i`=1, `nowrap_i`=0, fixed length) gives beat k the start address with its low bits XORed with k. The low bits are two bits for length 4 and three bits for length 8. The upper bits are unchanged.
- R4: Confined sequential order (`interleave_i`=0, `nowrap_i`=0, fixed length N) gives beat k the aligned block base of the start address plus ((start + k) mod N).
- R5: Unconfined sequential order (`nowrap_i`=1, fixed length) gives beat k the address start + k.
- R6: `len_sel_i` encodes 2'b00 as 4 words, 2'b01 as 8 words and 2'b1x as unbounded. An unbounded burst gives beat k the address (start + k) mod 2^ADDR_W, in sequential order whatever `interleave_i` and `nowrap_i` say.
- R7: A fixed burst presents exactly N beats. After `advance_i` is sampled on beat N-1, `addr_valid_o` is 0 in the next cycle.
- R8: If `stop_i` is sampled high during an active burst without `start_i`, `addr_valid_o` is 0 in the next cycle.
- R9: With `wait_early_i`=0, an unconfined fixed burst drives `wait_n_o` low exactly on the beat k>0 whose address is a multiple of 8.
- R10: With `wait_early_i`=1, `wait_n_o` is low instead on the beat just before that boundary beat.
- R11: `wait_n_o` is 1 whenever `addr_valid_o` is 0, and on every beat of confined or unbounded bursts.
- R12: A start with `interleave_i`=1 together with `nowrap_i`=1 or an unbounded length drives `cfg_err_o` high for the one cycle after the start. That burst then follows sequential order. `cfg_err_o` is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a burst with the current configuration |
| advance_i | input | 1 | Move to the next beat |
| stop_i | input | 1 | End the current burst |
| start_addr_i | input | ADDR_W | First word address of the burst |
| len_sel_i | input | 2 | 00 = 4 words, 01 = 8 words, 1x = unbounded |
| interleave_i | input | 1 | 1 = XOR-interleaved order |
| nowrap_i | input | 1 | 1 = sequential run past the aligned block |
| wait_early_i | input | 1 | 1 = mark the beat before the row boundary |
| addr_valid_o | output | 1 | A beat address is presented |
| addr_o | output | ADDR_W | Current beat address |
| wait_n_o | output | 1 | Low while the presented beat is marked invalid |
| cfg_err_o | output | 1 | One-cycle flag for an unsupported order request |

## Verification
Interleaved bursts are started from several odd and even offsets with arbitrary upper bits, so that an XOR order can be told apart from a rotating one. Confined and unconfined sequential bursts are started at the block's last word, so that wrapping to the base is told apart from running past it. Unconfined bursts that do and do not reach a row boundary are each run with both marker timings. Further cases cover an unbounded burst that rolls over the top address, a stalled burst, a restart that collides with a stop, and both forbidden interleaved combinations.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  // Address ordering resolved from the raw configuration
  typedef enum logic [1:0] {
    ORD_WRAP_LIN = 2'd0,  // sequential, confined to aligned block
    ORD_WRAP_XOR = 2'd1,  // interleaved, confined to aligned block
    ORD_INC      = 2'd2   // sequential, unconfined (also unbounded)
  } order_e;

  typedef struct packed {
    order_e order;
    logic   cont;   // unbounded length
    logic   len8;   // fixed length of eight (else four)
    logic   early;  // boundary marker one beat early
  } burst_mode_t;
endpackage

// File: rtl/burst_cfg_decode.sv
module burst_cfg_decode
  import burst_seq_pkg::*;
(
  input  logic [1:0]  len_sel_i,
  input  logic        interleave_i,
  input  logic        nowrap_i,
  input  logic        wait_early_i,
  output burst_mode_t mode_o,
  output logic        bad_o
);
  logic unconfined;

  always_comb begin
    unconfined     = len_sel_i[1] | nowrap_i;
    mode_o.cont    = len_sel_i[1];
    mode_o.len8    = ~len_sel_i[1] & len_sel_i[0];
    mode_o.early   = wait_early_i;
    if (unconfined)        mode_o.order = ORD_INC;
    else if (interleave_i) mode_o.order = ORD_WRAP_XOR;
    else                   mode_o.order = ORD_WRAP_LIN;
    bad_o = interleave_i & unconfined;
  end
endmodule

// File: rtl/burst_addr_calc.sv
module burst_addr_calc
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int ROW_W  = 3   // log2 of the boundary row size
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] beat_i,
  input  burst_mode_t       mode_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wait_req_o
);
  localparam int LOW_W = 3;  // widest fixed burst is 2**LOW_W words

  logic [ADDR_W-1:0] sum;
  logic [LOW_W-1:0]  span;
  logic [LOW_W-1:0]  last_beat;
  logic [LOW_W-1:0]  wrap_lo;
  logic [ROW_W-1:0]  next_lo;
  logic              fixed_inc;
  logic              cross_here;
  logic              cross_next;

  always_comb begin
    sum       = base_i + beat_i;
    span      = mode_i.len8 ? 3'b111 : 3'b011;
    last_beat = span;
    wrap_lo   = (base_i[LOW_W-1:0] & ~span) | (sum[LOW_W-1:0] & span);
    unique case (mode_i.order)
      ORD_WRAP_XOR: addr_o = {base_i[ADDR_W-1:LOW_W], base_i[LOW_W-1:0] ^ beat_i[LOW_W-1:0]};
      ORD_WRAP_LIN: addr_o = {base_i[ADDR_W-1:LOW_W], wrap_lo};
      default:      addr_o = sum;
    endcase
  end

  always_comb begin
    fixed_inc  = (mode_i.order == ORD_INC) && !mode_i.cont;
    next_lo    = sum[ROW_W-1:0] + 1'b1;
    cross_here = fixed_inc && (beat_i != '0) && (sum[ROW_W-1:0] == '0);
    cross_next = fixed_inc && (beat_i[LOW_W-1:0] != last_beat) && (next_lo == '0);
    wait_req_o = mode_i.early ? cross_next : cross_here;
  end
endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              advance_i,
  input  logic              stop_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  burst_mode_t       mode_i,
  output logic              active_n_o,
  output logic [ADDR_W-1:0] beat_n_o,
  output logic [ADDR_W-1:0] base_n_o,
  output burst_mode_t       mode_n_o,
  output logic              active_q_o,
  output burst_mode_t       mode_q_o
);
  logic              active_q;
  logic [ADDR_W-1:0] beat_q;
  logic [ADDR_W-1:0] base_q;
  burst_mode_t       mode_q;
  logic [ADDR_W-1:0] last_q;

  assign last_q = ADDR_W'({mode_q.len8, 2'b11});

  always_comb begin
    active_n_o = active_q;
    beat_n_o   = beat_q;
    base_n_o   = base_q;
    mode_n_o   = mode_q;
    if (start_i) begin
      active_n_o = 1'b1;
      beat_n_o   = '0;
      base_n_o   = start_addr_i;
      mode_n_o   = mode_i;
    end else if (active_q) begin
      if (stop_i) begin
        active_n_o = 1'b0;
      end else if (advance_i) begin
        if (!mode_q.cont && beat_q == last_q) active_n_o = 1'b0;
        else                                  beat_n_o   = beat_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      beat_q   <= '0;
      base_q   <= '0;
      mode_q   <= '{order: ORD_WRAP_LIN, cont: 1'b0, len8: 1'b0, early: 1'b0};
    end else begin
      active_q <= active_n_o;
      beat_q   <= beat_n_o;
      base_q   <= base_n_o;
      mode_q   <= mode_n_o;
    end
  end

  assign active_q_o = active_q;
  assign mode_q_o   = mode_q;

  // R7: a fixed burst never counts past its final beat
  assert_beat_bound_R7: assert property (@(posedge clk) disable iff (rst)
    (active_q && !mode_q.cont) |-> (beat_q <= last_q));
endmodule

// File: rtl/burst_seq_gen.sv
module burst_seq_gen
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              advance_i,
  input  logic              stop_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [1:0]        len_sel_i,
  input  logic              interleave_i,
  input  logic              nowrap_i,
  input  logic              wait_early_i,
  output logic              addr_valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wait_n_o,
  output logic              cfg_err_o
);
  burst_mode_t       dec_mode;
  logic              dec_bad;
  logic              active_n;
  logic [ADDR_W-1:0] beat_n;
  logic [ADDR_W-1:0] base_n;
  burst_mode_t       mode_n;
  logic              active_q;
  burst_mode_t       mode_q;
  logic [ADDR_W-1:0] calc_addr;
  logic              calc_wait;

  burst_cfg_decode u_dec (
    .len_sel_i   (len_sel_i),
    .interleave_i(interleave_i),
    .nowrap_i    (nowrap_i),
    .wait_early_i(wait_early_i),
    .mode_o      (dec_mode),
    .bad_o       (dec_bad)
  );

  burst_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .advance_i   (advance_i),
    .stop_i      (stop_i),
    .start_addr_i(start_addr_i),
    .mode_i      (dec_mode),
    .active_n_o  (active_n),
    .beat_n_o    (beat_n),
    .base_n_o    (base_n),
    .mode_n_o    (mode_n),
    .active_q_o  (active_q),
    .mode_q_o    (mode_q)
  );

  burst_addr_calc #(.ADDR_W(ADDR_W)) u_calc (
    .base_i    (base_n),
    .beat_i    (beat_n),
    .mode_i    (mode_n),
    .addr_o    (calc_addr),
    .wait_req_o(calc_wait)
  );

  // Registered outputs, computed from next-state values
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_valid_o <= 1'b0;
      addr_o       <= '0;
      wait_n_o     <= 1'b1;
      cfg_err_o    <= 1'b0;
    end else begin
      addr_valid_o <= active_n;
      addr_o       <= active_n ? calc_addr : '0;
      wait_n_o     <= !(active_n && calc_wait);
      cfg_err_o    <= start_i && dec_bad;
    end
  end

  // R1: first beat presents the start address
  assert_start_first_R1: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (addr_valid_o && addr_o == $past(start_addr_i)));

  // R2: outputs hold while no control input is sampled
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (addr_valid_o && !advance_i && !stop_i && !start_i)
      |=> (addr_valid_o && $stable(addr_o) && $stable(wait_n_o)));

  // R6: unbounded bursts step by one with rollover
  assert_cont_step_R6: assert property (@(posedge clk) disable iff (rst)
    (addr_valid_o && active_q && mode_q.cont && advance_i && !stop_i && !start_i)
      |=> (addr_valid_o && addr_o == $past(addr_o) + 1'b1));

  // R8: a stop without start ends the burst
  assert_stop_end_R8: assert property (@(posedge clk) disable iff (rst)
    (addr_valid_o && stop_i && !start_i) |=> !addr_valid_o);

  // R11: wait marker is inactive outside a burst
  assert_idle_wait_R11: assert property (@(posedge clk) disable iff (rst)
    !addr_valid_o |-> wait_n_o);

  // R12: a flagged configuration never runs interleaved
  assert_fallback_R12: assert property (@(posedge clk) disable iff (rst)
    cfg_err_o |-> (mode_q.order != ORD_WRAP_XOR));
endmodule

// File: tb/burst_seq_gen_test.sv
`timescale 1ns/1ps
module burst_seq_gen_test;
  localparam int AW = 21;

  typedef struct {
    logic [AW-1:0] a;
    logic          w;
    logic          e;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0, advance_i = 1'b0, stop_i = 1'b0;
  logic [AW-1:0] start_addr_i = '0;
  logic [1:0]    len_sel_i = 2'b00;
  logic          interleave_i = 1'b0, nowrap_i = 1'b0, wait_early_i = 1'b0;
  logic          addr_valid_o, wait_n_o, cfg_err_o;
  logic [AW-1:0] addr_o;

  int   checks = 0;
  int   fails  = 0;
  exp_t q[$];
  exp_t mon_e;

  always #4 clk = ~clk;  // 125 MHz

  burst_seq_gen #(.ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .advance_i(advance_i),
    .stop_i(stop_i), .start_addr_i(start_addr_i), .len_sel_i(len_sel_i),
    .interleave_i(interleave_i), .nowrap_i(nowrap_i), .wait_early_i(wait_early_i),
    .addr_valid_o(addr_valid_o), .addr_o(addr_o), .wait_n_o(wait_n_o),
    .cfg_err_o(cfg_err_o)
  );

  // Expected address of beat k, from the requirements
  function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] st, logic [1:0] ls,
                                             logic inter, logic nw, int k);
    int n = (ls == 2'b00) ? 4 : 8;
    if (ls[1] || nw) return st + AW'(k);
    if (inter)       return st ^ AW'(k);
    return (st & ~AW'(n - 1)) | AW'((int'(st[2:0]) + k) % n);
  endfunction

  function automatic logic exp_wait_n(logic [AW-1:0] st, logic [1:0] ls,
                                      logic nw, logic early, int k);
    int n = (ls == 2'b00) ? 4 : 8;
    int c = 0;
    if (ls[1] || !nw) return 1'b1;
    for (int j = 1; j < n; j++)
      if (((int'(st[2:0]) + j) % 8) == 0) c = j;
    if (c == 0) return 1'b1;
    return !(k == (early ? c - 1 : c));
  endfunction

  task automatic check_idle(string tag);
    checks++;
    if (addr_valid_o !== 1'b0 || wait_n_o !== 1'b1 || cfg_err_o !== 1'b0) begin
      fails++;
      $display("FAIL %s idle: valid=%0b wait_n=%0b err=%0b expected 0 1 0",
               tag, addr_valid_o, wait_n_o, cfg_err_o);
    end
  endtask

  // endm: 0 natural end, 1 stop on last beat, 2 leave active for a restart
  task automatic do_burst(logic [AW-1:0] st, logic [1:0] ls, logic inter, logic nw,
                          logic early, int nb, bit stall, int endm, bit stop_w_start,
                          string tag);
    logic bad = inter && (ls[1] || nw);
    for (int k = 0; k < nb; k++) begin
      exp_t it;
      it.a   = exp_addr(st, ls, bad ? 1'b0 : inter, nw, k);
      it.w   = exp_wait_n(st, ls, nw, early, k);
      it.e   = bad && (k == 0);
      it.tag = tag;
      q.push_back(it);
    end
    @(posedge clk); #2;
    start_i = 1'b1; start_addr_i = st; len_sel_i = ls; interleave_i = inter;
    nowrap_i = nw; wait_early_i = early; advance_i = 1'b0; stop_i = stop_w_start;
    for (int i = 0; i < nb; i++) begin
      @(posedge clk); #2;
      start_i = 1'b0; stop_i = 1'b0; advance_i = 1'b0;
      if (stall && (i % 2 == 1)) begin
        @(posedge clk); #2;
      end
      if (i < nb - 1)     advance_i = 1'b1;
      else if (endm == 0) advance_i = 1'b1;
      else if (endm == 1) stop_i = 1'b1;
    end
    if (endm != 2) begin
      @(posedge clk); #2;
      advance_i = 1'b0; stop_i = 1'b0;
      @(negedge clk);
      check_idle(endm == 0 ? "R7" : "R8");
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && addr_valid_o) begin
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R7 unexpected beat addr=%h expected no beat", addr_o);
      end else begin
        mon_e = q[0];
        if (addr_o !== mon_e.a || wait_n_o !== mon_e.w || cfg_err_o !== mon_e.e) begin
          fails++;
          $display("FAIL %s addr=%h wait_n=%0b err=%0b expected %h %0b %0b",
                   mon_e.tag, addr_o, wait_n_o, cfg_err_o, mon_e.a, mon_e.w, mon_e.e);
        end
        if (advance_i || stop_i || start_i) void'(q.pop_front());
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired, expected test completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    check_idle("R11");                                                // reset state
    // R3 interleaved, with stall for R2
    do_burst(21'h0A3451, 2'b01, 1, 0, 0, 8, 1, 0, 0, "R3");
    do_burst(21'h1F0003, 2'b01, 1, 0, 0, 8, 0, 0, 0, "R3");
    do_burst(21'h000006, 2'b00, 1, 0, 0, 4, 1, 0, 0, "R2");
    // R4 confined sequential
    do_burst(21'h000A01, 2'b00, 0, 0, 0, 4, 0, 0, 0, "R4");
    do_burst(21'h123455, 2'b01, 0, 0, 0, 8, 0, 0, 0, "R4");
    do_burst(21'h000017, 2'b01, 0, 0, 1, 8, 0, 0, 0, "R11");          // no marker when confined
    // R5 unconfined, R9/R10 row-boundary marker
    do_burst(21'h000003, 2'b00, 0, 1, 0, 4, 0, 0, 0, "R5");
    do_burst(21'h000007, 2'b01, 0, 1, 0, 8, 0, 0, 0, "R9");
    do_burst(21'h000007, 2'b01, 0, 1, 1, 8, 1, 0, 0, "R10");
    do_burst(21'h00F0F5, 2'b00, 0, 1, 0, 4, 0, 0, 0, "R9");
    do_burst(21'h00F0F5, 2'b00, 0, 1, 1, 4, 0, 0, 0, "R10");
    do_burst(21'h000010, 2'b01, 0, 1, 1, 8, 0, 0, 0, "R5");
    // R6 unbounded with rollover, ended by stop (R8)
    do_burst(21'h1FFFFD, 2'b10, 0, 0, 0, 6, 0, 1, 0, "R6");
    do_burst(21'h000100, 2'b11, 0, 1, 1, 12, 1, 1, 0, "R6");
    // R12 forbidden interleaved combinations
    do_burst(21'h000002, 2'b01, 1, 1, 0, 8, 0, 0, 0, "R12");
    do_burst(21'h000004, 2'b10, 1, 0, 0, 5, 0, 1, 0, "R12");
    // R1 restart during a burst, colliding with stop
    do_burst(21'h000040, 2'b01, 0, 0, 0, 3, 0, 2, 0, "R1");
    do_burst(21'h000062, 2'b00, 1, 0, 0, 4, 0, 0, 1, "R1");
    repeat (2) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R7 %0d beats never seen, expected 0", q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule